// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block gathers a vector of independent level interrupt sources into a single parent interrupt line. Every source has one bit in a pending register, which latches whenever the source is high and stays set until software acknowledges it. Every source also has one bit in a mask register. The parent line is raised while any pending bit is also unmasked.

Software reaches both registers through a single-cycle 32-bit read/write port. It acknowledges a source with a read-modify-write of the pending register. Bits written as 0 are cleared and bits written as 1 are kept, so software clears exactly the bit it zeroed. Writing zero to both registers masks and clears everything. A source that is still high when its bit is cleared sets the bit again, so no level request is lost. Pending bits latch whatever the mask says, so unmasking a source that is already pending raises the parent line.

Top module: `irq_sticky_agg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending and mask registers become all zeros and `irq_o` becomes low.
- R2: Pending bit i (bit i of the register at byte offset 0) is set at any clock edge where `src_i[i]` is high, whatever mask bit i holds. It stays set after the source falls until it is cleared.
- R3: A write to byte offset 0 clears every pending bit whose data bit is 0 and leaves every pending bit whose data bit is 1 unchanged.
- R4: If a source is high in the same cycle as a write that clears its pending bit, the bit stays set.
- R5: A write to byte offset 4 loads the mask register with the write data, where bit i = 1 unmasks source i. Rewriting the read value with one bit changed alters only that source's masking.
- R6: `irq_o` is registered. It equals the OR over all bits of (pending AND mask) as that value stood one clock edge earlier.
- R7: Unmasking a source whose pending bit is already set raises `irq_o` one clock edge after the mask write takes effect.
- R8: `rdata_o` combinationally returns the current pending register when `addr_i` is 0 and the current mask register when `addr_i` is 4, so a read after a write reflects the write.
- R9: Writes to any byte offset other than 0 or 4 change neither register, and reads from such offsets return zero.
- R10: Writing zero to offset 4 and then to offset 0, with all sources low, leaves both registers zero and drives `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Level interrupt sources, one per bit |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Byte address of the register port |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Aggregated parent interrupt, registered |

## Verification
Pending and mask updates show up on `rdata_o` right after the clock edge that samples the source or the write. `irq_o` follows one further edge later. Each table step therefore drives its stimulus for one edge and reads both registers back at the next falling edge with sources and writes idle. It then lets one more idle edge pass before comparing `irq_o` with the OR of the expected pending and mask values. Directed tests sample `irq_o` both at the edge where a pending bit appears and at the edge after it, to show the one-cycle lag exactly.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants and types for the sticky interrupt aggregator.
// Assumes byte addressing with word registers at fixed offsets.
package irq_agg_pkg;

    localparam int unsigned SRC_COUNT   = 32;
    localparam int unsigned PORT_ADDR_W = 8;
    localparam int unsigned PEND_OFS    = 0;
    localparam int unsigned MASK_OFS    = 4;

    // Register selected by the current port address.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irq_agg_decode.sv
// Module: address decode and read-data multiplexer.
// Assumes a single-cycle port: the write strobe acts at the next clock edge
// and the read data is purely combinational from the address.
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int unsigned DATA_W   = SRC_COUNT,
    parameter int unsigned ADDR_W   = PORT_ADDR_W,
    parameter int unsigned PEND_ADR = PEND_OFS,
    parameter int unsigned MASK_ADR = MASK_OFS
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] pend_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic              pend_wr_o,
    output logic              mask_wr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_ADR);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADR);

    reg_sel_e sel;

    // Map the address to a register, or to none.
    always_comb begin
        if (addr_i == PEND_A)      sel = SEL_PEND;
        else if (addr_i == MASK_A) sel = SEL_MASK;
        else                       sel = SEL_NONE;
    end

    // Qualify the write strobe per register.
    always_comb begin
        pend_wr_o = wr_en_i && (sel == SEL_PEND);
        mask_wr_o = wr_en_i && (sel == SEL_MASK);
    end

    // Return register contents, zero for unmapped offsets.
    always_comb begin
        case (sel)
            SEL_PEND: rdata_o = pend_i;
            SEL_MASK: rdata_o = mask_i;
            default:  rdata_o = '0;
        endcase
    end

    // R9: unmapped offsets never strobe a register
    always_comb begin
        AST_UNMAPPED_NO_WR: assert (!(sel == SEL_NONE && (pend_wr_o || mask_wr_o))); // R9
    end

endmodule

// File: rtl/irq_agg_pending.sv
// Module: sticky pending register, one bit per source.
// Assumes level sources sampled every clock; set has priority over clear.
module irq_agg_pending #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        // Latch source b, clear on a zero write unless the source is high.
        always_ff @(posedge clk) begin
            if (!rst_n)                    pend_q[b] <= 1'b0;
            else if (src_i[b])             pend_q[b] <= 1'b1;
            else if (wr_i && !wdata_i[b])  pend_q[b] <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    AST_PEND_RESET: assert property (@(posedge clk) !rst_n |=> pend_q == '0); // R1

    AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((pend_q & $past(src_i)) == $past(src_i))); // R2

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && src_i == '0) |=> $stable(pend_q)); // R2

    AST_PEND_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && src_i == '0) |=> pend_q == ($past(pend_q) & $past(wdata_i))); // R3

    AST_PEND_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((pend_q & $past(src_i)) == $past(src_i))); // R4

endmodule

// File: rtl/irq_agg_mask.sv
// Module: mask register, bit set means the source is unmasked.
// Assumes full-word writes; software does read-modify-write per bit.
module irq_agg_mask #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] mask_o
);

    logic [N-1:0] mask_q;

    // Load the whole mask word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (wr_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    AST_MASK_RESET: assert property (@(posedge clk) !rst_n |=> mask_q == '0); // R1

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> mask_q == $past(wdata_i)); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_q)); // R5

endmodule

// File: rtl/irq_agg_out.sv
// Module: registered parent interrupt from pending AND mask.
// Assumes one cycle of latency is acceptable to the parent controller.
module irq_agg_out #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);

    logic irq_q;

    // Register the reduction of unmasked pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend_i & mask_i);
    end

    assign irq_o = irq_q;

    AST_IRQ_RESET: assert property (@(posedge clk) !rst_n |=> !irq_q); // R1

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_q == $past(|(pend_i & mask_i))); // R6

    AST_IRQ_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & mask_i) != '0) |=> irq_q); // R7

endmodule

// File: rtl/irq_sticky_agg.sv
// Module: top of the masked sticky interrupt aggregator.
// Collects N level sources into one registered parent line through a
// pending register (offset 0) and a mask register (offset 4).
// Assumes synchronous active-low reset and a single-cycle register port.
module irq_sticky_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC    = SRC_COUNT,
    parameter int unsigned ADDR_W   = PORT_ADDR_W,
    parameter int unsigned PEND_ADR = PEND_OFS,
    parameter int unsigned MASK_ADR = MASK_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N_SRC-1:0]  wdata_i,
    output logic [N_SRC-1:0]  rdata_o,
    output logic              irq_o
);

    logic             pend_wr;
    logic             mask_wr;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] mask;

    irq_agg_decode #(
        .DATA_W   (N_SRC),
        .ADDR_W   (ADDR_W),
        .PEND_ADR (PEND_ADR),
        .MASK_ADR (MASK_ADR)
    ) u_decode (
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .pend_i    (pend),
        .mask_i    (mask),
        .pend_wr_o (pend_wr),
        .mask_wr_o (mask_wr),
        .rdata_o   (rdata_o)
    );

    irq_agg_pending #(.N(N_SRC)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .wr_i    (pend_wr),
        .wdata_i (wdata_i),
        .pend_o  (pend)
    );

    irq_agg_mask #(.N(N_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (wdata_i),
        .mask_o  (mask)
    );

    irq_agg_out #(.N(N_SRC)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .mask_i (mask),
        .irq_o  (irq_o)
    );

    // R9: a write to an unmapped offset leaves both registers unchanged
    AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i != ADDR_W'(PEND_ADR) && addr_i != ADDR_W'(MASK_ADR)
         && src_i == '0) |=> ($stable(pend) && $stable(mask))); // R9

endmodule

// File: tb/irq_sticky_agg_bench.sv
// Bench: table-driven steps, then directed reset and corner-case tests.
module irq_sticky_agg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_sticky_agg u_irq_sticky_agg (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // Stimulus: source, write strobe, address, data; expected pending, mask, irq.
    localparam logic [31:0] V_SRC [NV] = '{
        32'h0000_0005, 32'h0, 32'h0, 32'h0, 32'h8000_0000, 32'h0, 32'h8000_0000,
        32'h0, 32'h0001_0100, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic        V_WR  [NV] = '{
        1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [7:0]  V_ADR [NV] = '{
        8'h0, 8'h4, 8'h0, 8'h4, 8'h0, 8'h4, 8'h0, 8'h0, 8'h8, 8'h4, 8'hC, 8'h4, 8'h0};
    localparam logic [31:0] V_WD  [NV] = '{
        32'h0, 32'h0000_0001, 32'hFFFF_FFFE, 32'h0000_0005, 32'hFFFF_FFFB,
        32'h8000_0005, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0};
    localparam logic [31:0] V_EP  [NV] = '{
        32'h5, 32'h5, 32'h4, 32'h4, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000,
        32'h0, 32'h0001_0100, 32'h0001_0100, 32'h0001_0100, 32'h0001_0100, 32'h0};
    localparam logic [31:0] V_EM  [NV] = '{
        32'h0, 32'h1, 32'h1, 32'h5, 32'h5, 32'h8000_0005, 32'h8000_0005,
        32'h8000_0005, 32'h8000_0005, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    localparam logic        V_EI  [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam string       V_REQ [NV] = '{
        "R2", "R5", "R3", "R7", "R3", "R5", "R4", "R3", "R9", "R10", "R9", "R7", "R10"};

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then return to idle at the next falling edge.
    task automatic drive(input logic [31:0] s, input logic w, input logic [7:0] a,
                         input logic [31:0] d);
        @(negedge clk);
        src = s; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        src = '0; wr_en = 1'b0;
    endtask

    task automatic read_at(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        logic [31:0] v;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        read_at(8'h0, v); check32("R1 pending", v, 32'h0);
        read_at(8'h4, v); check32("R1 mask", v, 32'h0);
        check1("R1 irq", irq, 1'b0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(V_SRC[i], V_WR[i], V_ADR[i], V_WD[i]);
            read_at(8'h0, v); check32({V_REQ[i], " R8 pending"}, v, V_EP[i]);
            read_at(8'h4, v); check32({V_REQ[i], " R8 mask"}, v, V_EM[i]);
            @(negedge clk);
            check1({V_REQ[i], " R6 irq"}, irq, V_EI[i]);
        end

        // R9: unmapped read returns zero while registers are non-zero
        drive(32'h0000_00F0, 1'b1, 8'h4, 32'h0000_0010);
        read_at(8'h8, v); check32("R9 read unmapped", v, 32'h0);
        read_at(8'h0, v); check32("R2 pending masked-off bits", v, 32'h0000_00F0);

        // R6: exact one-cycle lag of irq after the pending bit rises
        drive(32'h0, 1'b1, 8'h0, 32'h0);
        @(negedge clk);
        check1("R6 irq cleared", irq, 1'b0);
        @(negedge clk);
        src = 32'h0000_0010;
        @(posedge clk);
        #1;
        src = '0;
        check1("R6 irq not yet", irq, 1'b0);
        @(posedge clk);
        #1;
        check1("R6 irq after lag", irq, 1'b1);

        // R5: read-modify-write changes only one mask bit
        @(negedge clk);
        read_at(8'h4, v);
        drive(32'h0, 1'b1, 8'h4, v | 32'h0000_0200);
        read_at(8'h4, v); check32("R5 rmw mask", v, 32'h0000_0210);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_at(8'h0, v); check32("R1 pending after reset", v, 32'h0);
        read_at(8'h4, v); check32("R1 mask after reset", v, 32'h0);
        check1("R1 irq after reset", irq, 1'b0);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule